// File: doc/BRIEF.md
# First-Order Noise-Shaping Modulator

This block turns a stream of signed Q1.15 audio samples into a coarse pulse stream for a pin-level output stage. It runs on a modulator clock that is the audio sample rate multiplied by an oversampling factor `OSR` (32, 64, 128 or 256). On every modulator cycle it subtracts the level it quantised on the previous cycle from the held input sample, adds the difference into a 20-bit error integrator, and quantises the new integrator value. Averaged over time, the pulse levels therefore follow the input, and the quantisation error is pushed towards high frequencies where an external low-pass filter removes it.

The quantiser is picked at elaboration time. The two-level variant drives a single pin. The three-level variant drives a pair of pins that encode negative, zero and positive. A small pseudo-random dither, taken from a 16-bit maximal-length LFSR, can be added in front of the quantiser while `dither_on` is high.

Samples arrive over a valid/ready handshake. The modulator raises `smp_ready` for one cycle in every `OSR` cycles. A sample transfers when `smp_valid` and `smp_ready` are high on the same edge, and it is then held for the next `OSR` cycles. The producer must keep `smp_data` stable while `smp_valid` is high and no transfer has happened. If no sample is offered at a strobe, the modulator keeps using the sample it already holds. A transfer cannot be stalled; the only back-pressure is the fixed cadence of `smp_ready`.

Top module: `nsm_first_order`

## Requirements
- R1: `smp_ready` is high for exactly one cycle in every `OSR` cycles. A sample is captured on the edge where `smp_valid` and `smp_ready` are both high, and it feeds the integrator from the following edge onwards.
- R2: On an edge where `smp_ready` is low, or `smp_valid` is low, the held sample does not change. Whatever is on `smp_data` at that edge has no effect on the output.
- R3: On each edge the integrator takes the value acc + x - f. Here x is the held sample as a signed integer (full scale 1.0 = 32768), and f is +32768, 0 or -32768 for the level currently on the pins. The integrator uses 20-bit two's-complement arithmetic, and its magnitude never exceeds 65544.
- R4: In two-level mode the registered decision is positive (`out_pos`=1) when the new integrator value plus dither is greater than zero. Otherwise it is negative (`out_pos`=0). `out_neg` stays 0.
- R5: In three-level mode the pins {`out_pos`,`out_neg`} read 10 for +1 when the new integrator value plus dither exceeds 16384. They read 01 for -1 when that value is below -16384, and 00 for 0 otherwise. The pair 11 never appears.
- R6: While `dither_on` is low, the decision depends only on the new integrator value, exactly as in R4 and R5.
- R7: While `dither_on` is high, a value in the range -2 to +1, drawn from the LFSR, is added before the quantiser. A decision can therefore differ from the undithered one only when the integrator value lies within 2 of a threshold.
- R8: A synchronous reset `rst` clears the integrator and the held sample, drives both pins low (the -1 level in two-level mode, the zero level in three-level mode) and lowers `smp_ready`. The first strobe after reset comes `OSR`-1 cycles after `rst` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock, OSR times the sample rate |
| rst | input | 1 | Synchronous reset, active high |
| dither_on | input | 1 | Adds LFSR dither in front of the quantiser |
| smp_valid | input | 1 | Producer offers a sample |
| smp_ready | output | 1 | One-cycle sample strobe, once every OSR cycles |
| smp_data | input | SAMPLE_W | Signed Q1.15 input sample |
| out_pos | output | 1 | Positive-level pin (the only pin in two-level mode) |
| out_neg | output | 1 | Negative-level pin (three-level mode, else 0) |

## Verification
The hardest situations to reach from the ports are an integrator that lands right at a quantiser threshold, and a strobe where a sample is offered on a cycle that is not a strobe. Neither one shows directly on the pins. The stimulus sweeps the held input across the whole Q1.15 range in steps of 1024, so the integrator walks through every threshold region in both quantiser variants, with dither off and then on. The bench rebuilds the integrator from the observed pin levels, so it can tell exactly when a value falls inside the dither band. Each input is offered once and then replaced by its inverse while `smp_valid` is low, which shows whether a wrong capture reached the pins.

// File: rtl/nsm_pkg.sv
package nsm_pkg;
  // Quantised level, encoded as the pin pair {pos, neg}
  typedef enum logic [1:0] {
    LVL_ZERO = 2'b00,
    LVL_NEG  = 2'b01,
    LVL_POS  = 2'b10
  } lvl_e;
endpackage

// File: rtl/nsm_sample_gate.sv
module nsm_sample_gate #(
  parameter int SAMPLE_W = 16,
  parameter int OSR      = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic [SAMPLE_W-1:0] hold_o
);
  localparam int CNT_W = $clog2(OSR);

  logic [CNT_W-1:0] cnt;

  assign smp_ready = (cnt == CNT_W'(OSR - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      hold_o <= '0;
    end else begin
      cnt <= smp_ready ? '0 : cnt + 1'b1;
      if (smp_ready && smp_valid) hold_o <= smp_data;
    end
  end

  // R1: the strobe never lasts longer than one cycle
  p_strobe_single_r1: assert property (@(posedge clk) disable iff (rst)
    smp_ready |=> !smp_ready);
  // R1: an accepted sample is the one that is held afterwards
  p_capture_r1: assert property (@(posedge clk) disable iff (rst)
    (smp_ready && smp_valid) |=> (hold_o == $past(smp_data)));
  // R2: the held sample does not move without a transfer
  p_hold_kept_r2: assert property (@(posedge clk) disable iff (rst)
    !(smp_ready && smp_valid) |=> $stable(hold_o));
endmodule

// File: rtl/nsm_dither.sv
module nsm_dither #(
  parameter int DW = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en_i,
  output logic signed [DW-1:0] dith_o
);
  localparam logic [15:0] SEED = 16'hACE1;
  localparam logic [15:0] TAPS = 16'hB400;

  logic [15:0] lfsr;

  always_ff @(posedge clk) begin
    if (rst) lfsr <= SEED;
    else     lfsr <= lfsr[0] ? ((lfsr >> 1) ^ TAPS) : (lfsr >> 1);
  end

  assign dith_o = en_i ? lfsr[DW-1:0] : '0;

  // R7: the dither source never collapses into the all-zero lock-up state
  p_lfsr_alive_r7: assert property (@(posedge clk) disable iff (rst)
    lfsr != '0);
endmodule

// File: rtl/nsm_quant.sv
module nsm_quant
  import nsm_pkg::*;
#(
  parameter int ACC_W       = 20,
  parameter int SAMPLE_W    = 16,
  parameter bit THREE_LEVEL = 1'b0
) (
  input  logic signed [ACC_W-1:0] v_i,
  output lvl_e                    lvl_o
);
  generate
    if (THREE_LEVEL) begin : g_three
      localparam logic signed [ACC_W-1:0] HALF_P = ACC_W'(1 << (SAMPLE_W - 2));
      localparam logic signed [ACC_W-1:0] HALF_N = -HALF_P;
      always_comb begin
        if (v_i > HALF_P)      lvl_o = LVL_POS;
        else if (v_i < HALF_N) lvl_o = LVL_NEG;
        else                   lvl_o = LVL_ZERO;
      end
    end else begin : g_two
      always_comb begin
        lvl_o = (!v_i[ACC_W-1] && (v_i != '0)) ? LVL_POS : LVL_NEG;
      end
    end
  endgenerate
endmodule

// File: rtl/nsm_first_order.sv
module nsm_first_order
  import nsm_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int ACC_W       = 20,
  parameter int OSR         = 32,
  parameter bit THREE_LEVEL = 1'b0,
  parameter int DITH_W      = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dither_on,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic                out_pos,
  output logic                out_neg
);
  localparam int EXT_W = ACC_W - SAMPLE_W;
  localparam logic signed [ACC_W-1:0] FS_P  = ACC_W'(1 << (SAMPLE_W - 1));
  localparam logic signed [ACC_W-1:0] FS_N  = -FS_P;
  localparam logic signed [ACC_W-1:0] BOUND = ACC_W'((2 << (SAMPLE_W - 1)) + 8);
  localparam lvl_e RST_LVL = THREE_LEVEL ? LVL_ZERO : LVL_NEG;

  logic [SAMPLE_W-1:0]       hold;
  logic signed [DITH_W-1:0]  dith;
  logic signed [ACC_W-1:0]   acc, acc_nxt, x_ext, fb, dith_ext, q_in;
  lvl_e                      lvl_q, lvl_d;

  nsm_sample_gate #(.SAMPLE_W(SAMPLE_W), .OSR(OSR)) gate_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .hold_o(hold)
  );

  nsm_dither #(.DW(DITH_W)) dith_i (
    .clk(clk), .rst(rst), .en_i(dither_on), .dith_o(dith)
  );

  assign x_ext    = {{EXT_W{hold[SAMPLE_W-1]}}, hold};
  assign dith_ext = {{(ACC_W - DITH_W){dith[DITH_W-1]}}, dith};

  always_comb begin
    case (lvl_q)
      LVL_POS: fb = FS_P;
      LVL_NEG: fb = FS_N;
      default: fb = '0;
    endcase
  end

  assign acc_nxt = acc + x_ext - fb;
  assign q_in    = acc_nxt + dith_ext;

  nsm_quant #(.ACC_W(ACC_W), .SAMPLE_W(SAMPLE_W), .THREE_LEVEL(THREE_LEVEL)) quant_i (
    .v_i(q_in), .lvl_o(lvl_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      lvl_q <= RST_LVL;
    end else begin
      acc   <= acc_nxt;
      lvl_q <= lvl_d;
    end
  end

  assign out_pos = (lvl_q == LVL_POS);

  generate
    if (THREE_LEVEL) begin : g_pins3
      assign out_neg = (lvl_q == LVL_NEG);
      // R5: the pin pair never shows the unused code 11
      p_pins_legal_r5: assert property (@(posedge clk) disable iff (rst)
        !(out_pos && out_neg));
    end else begin : g_pins2
      assign out_neg = 1'b0;
      // R4: in two-level mode the integrator falls after a positive decision
      p_pos_pulls_down_r4: assert property (@(posedge clk) disable iff (rst)
        out_pos |=> (acc <= $past(acc)));
    end
  endgenerate

  // R3: the integrator stays inside its headroom
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (acc <= BOUND) && (acc >= -BOUND));
  // R8: reset leaves a cleared integrator and idle pins
  p_reset_state_r8: assert property (@(posedge clk)
    rst |=> (acc == '0) && !out_pos && !out_neg && !smp_ready);
endmodule

// File: tb/nsm_first_order_tb.sv
module nsm_first_order_tb_top;
  localparam int OSR = 32;
  localparam int LIM = 65544;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dither_on = 1'b0;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic        rdy2, rdy3, pos2, neg2, pos3, neg3;

  always #10 clk = ~clk;

  nsm_first_order #(.OSR(OSR), .THREE_LEVEL(1'b0)) dut_i (
    .clk(clk), .rst(rst), .dither_on(dither_on), .smp_valid(smp_valid),
    .smp_ready(rdy2), .smp_data(smp_data), .out_pos(pos2), .out_neg(neg2)
  );
  nsm_first_order #(.OSR(OSR), .THREE_LEVEL(1'b1)) dut3_i (
    .clk(clk), .rst(rst), .dither_on(dither_on), .smp_valid(smp_valid),
    .smp_ready(rdy3), .smp_data(smp_data), .out_pos(pos3), .out_neg(neg3)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  int acc_m[2];
  int lvl_m[2];
  int hold_m;
  int since;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic int obs_level(input bit three, input logic p, input logic n);
    if (!three) return p ? 1 : -1;
    if (p && n) return 99;
    return p ? 1 : (n ? -1 : 0);
  endfunction

  // Expected level from the integrator value; amb marks the dither band
  function automatic int exp_level(input bit three, input int a, input bit den, output bit amb);
    amb = 1'b0;
    if (!three) begin
      if (den && a >= 0 && a <= 2) amb = 1'b1;
      return (a > 0) ? 1 : -1;
    end
    if (den && ((a >= 16384 && a <= 16386) || (a >= -16385 && a <= -16383))) amb = 1'b1;
    if (a > 16384) return 1;
    if (a < -16384) return -1;
    return 0;
  endfunction

  task automatic reset_model();
    acc_m[0] = 0; acc_m[1] = 0;
    lvl_m[0] = -1; lvl_m[1] = 0;
    hold_m = 0; since = 0;
  endtask

  task automatic step(input logic v, input logic [15:0] d, output bit took);
    int  an[2];
    bit  rdy, amb;
    int  e, o;
    smp_valid = v;
    smp_data  = d;
    rdy = rdy2;
    chk(rdy2 == rdy3, "R1 strobe equal in both variants", int'(rdy3), int'(rdy2));
    for (int k = 0; k < 2; k++) an[k] = acc_m[k] + hold_m - 32768 * lvl_m[k];
    if (rdy) begin
      chk(since == OSR - 1, "R1 strobe spacing", since, OSR - 1);
      since = 0;
    end else begin
      since++;
    end
    @(posedge clk);
    @(negedge clk);
    took = rdy && v;
    if (took) hold_m = int'($signed(d));
    for (int k = 0; k < 2; k++) begin
      o = (k == 0) ? obs_level(1'b0, pos2, neg2) : obs_level(1'b1, pos3, neg3);
      e = exp_level(k == 1, an[k], dither_on, amb);
      if (k == 0) chk(neg2 == 1'b0, "R4 second pin idle", int'(neg2), 0);
      else        chk(o != 99, "R5 pin code 11", o, e);
      if (amb) chk(o >= -1 && o <= 1, "R7 level inside dither band", o, e);
      else if (dither_on) chk(o == e, (k == 0) ? "R7 two-level" : "R7 three-level", o, e);
      else chk(o == e, (k == 0) ? "R6 R4 two-level decision" : "R6 R5 three-level decision", o, e);
      if (o != 99) lvl_m[k] = o;
      acc_m[k] = an[k];
      chk(an[k] <= LIM && an[k] >= -LIM, "R3 integrator bound", an[k], LIM);
    end
  endtask

  initial begin
    bit took, taken;
    logic [15:0] x16;
    reset_model();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!pos2 && !neg2 && !pos3 && !neg3, "R8 pins low in reset", int'({pos2, neg2, pos3, neg3}), 0);
    chk(!rdy2 && !rdy3, "R8 strobe low in reset", int'({rdy2, rdy3}), 0);
    rst = 1'b0;

    for (int pass = 0; pass < 2; pass++) begin
      dither_on = (pass == 1);
      for (int i = 0; i < 65; i++) begin
        x16 = (i == 64) ? 16'h7FFF : 16'(-32768 + i * 1024);
        taken = 1'b0;
        for (int c = 0; c < 4 * OSR; c++) begin
          // R2: after the capture the inverse value is offered with valid low
          step(!taken, taken ? ~x16 : x16, took);
          if (took) taken = 1'b1;
        end
        chk(taken, "R1 sample accepted in its frame", int'(taken), 1);
      end
    end

    // R8: mid-run reset, then idle input must behave as a zero sample
    dither_on = 1'b0;
    smp_valid = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(!pos2 && !neg2 && !pos3 && !neg3, "R8 pins low after reset", int'({pos2, neg2, pos3, neg3}), 0);
    chk(!rdy2 && !rdy3, "R8 strobe low after reset", int'({rdy2, rdy3}), 0);
    rst = 1'b0;
    reset_model();
    for (int c = 0; c < 3 * OSR; c++) step(1'b0, 16'h4000, took);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule